// File: doc/BRIEF.md
# Dual-Channel Serial Sample Port

This block turns pairs of 16-bit receive samples into a serial stream on one data pin. It generates its own bit clock by dividing the system clock, and it marks the start of each frame with a sync pulse. Each sample strobe from the receive path loads both channel words into holding registers and requests one frame. The frame carries the channel A word and then the channel B word, most significant bit first. Either word can be left out.

Two write-only registers configure the port. They are written through `wr_en`, `wr_addr` and `wr_data`. Address 0 holds the clock divide code. Address 1 holds the control bits: bit 0 enables the port, bit 1 selects channel A, bit 2 selects channel B, bit 3 tri-states the idle data pin, and bit 4 inverts the bit clock. A disable request takes effect only after any frame in flight has finished. Frames may follow one another with no gap.

Top module: `rx_sample_port`

## Requirements
- R1: With divide code D (2..255, and 0 meaning 256), the bit clock period is N = D system clocks. Each period starts with a high phase of floor(N/2) clocks, followed by a low phase of N - floor(N/2) clocks, as seen on the pin when not inverted.
- R2: After reset both registers are zero. The bit clock, frame sync and data pin are all low, and the data pin is driven (`sdata_oe` = 1).
- R3: Frame sync is high for exactly one bit period, the one just before the first data bit. Data changes on the falling edge of the bit clock, so it is stable at each rising edge. Bits go out MSB first, channel A before channel B.
- R4: Control bit 1 includes the channel A word and control bit 2 includes the channel B word. A deselected word is omitted, so a frame is 16 bits with one channel selected and 32 bits with both.
- R5: When control bit 0 is clear, the bit clock is held low and strobes are discarded. When neither channel is selected, a strobe produces no frame sync and no frame.
- R6: Between frames, the data pin is released (`sdata_oe` = 0) when control bit 3 is set, and driven low when it is clear. During data bits `sdata_oe` is always 1.
- R7: If control bit 0 is cleared during a frame, that frame is sent in full. The bit clock then stops, held low.
- R8: When control bit 4 is set, the bit clock pin is inverted while it runs. The bit is taken only by writes made while the clock is stopped; writes made while it runs leave the inversion unchanged.
- R9: A strobe that arrives during a frame is held. Its frame sync then falls in the last data bit period of the current frame, so the next frame follows with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = divide code, 1 = control |
| wr_data | input | 8 | Register write data |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_a | input | SW | Channel A sample |
| smp_b | input | SW | Channel B sample |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync pulse |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Data pin output enable |

## Verification
The bench builds the block with the default word width SW = 16. This makes both 16-bit and 32-bit frames observable. Through the divide register it uses codes 4 and 5 for short bit periods, which lets many frames and the odd-divide phase split be checked in a few thousand cycles. It also runs code 0 once, to check the 256-clock period. The small divide codes also allow a disable to be requested in the middle of a frame and a second strobe to be placed inside a running frame, so the drain and back-to-back cases are both exercised.

// File: rtl/rx_sample_port.sv
module rx_sample_port #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          smp_stb,
  input  logic [SW-1:0] smp_a,
  input  logic [SW-1:0] smp_b,
  output logic          bclk,
  output logic          fsync,
  output logic          sdata,
  output logic          sdata_oe
);
  localparam int FW = 2 * SW;
  localparam int LW = $clog2(FW + 1);

  logic [7:0] div_r;
  logic [3:0] ctl_r;
  logic       inv_q;
  logic       en, sel_a, sel_b, idle_hiz;
  logic       unused_hi;

  assign en        = ctl_r[0];
  assign sel_a     = ctl_r[1];
  assign sel_b     = ctl_r[2];
  assign idle_hiz  = ctl_r[3];
  assign unused_hi = ^wr_data[7:5];

  logic          armed, active, pending, dout, running, fall, fs_go;
  logic [7:0]    cnt, half, last;
  logic [LW-1:0] left, left_nxt, len_q;
  logic [FW-1:0] sh, frame;
  logic [SW-1:0] hold_a, hold_b;

  assign running = en | armed | active;
  assign half    = (div_r == 8'd0) ? 8'd128 : {1'b0, div_r[7:1]};
  assign last    = div_r - 8'd1;
  assign fall    = running && (cnt == half - 8'd1);
  assign bclk    = running & ((cnt < half) ^ inv_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_r <= '0;
      ctl_r <= '0;
      inv_q <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr) div_r <= wr_data;
      else begin
        ctl_r <= wr_data[3:0];
        if (!running) inv_q <= wr_data[4];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    cnt <= '0;
    else if (!running || cnt == last) cnt <= '0;
    else                           cnt <= cnt + 8'd1;

  always_comb begin
    if (armed)          left_nxt = len_q - LW'(1);
    else if (left != 0) left_nxt = left - LW'(1);
    else                left_nxt = '0;
  end

  assign fs_go = pending && (sel_a | sel_b) && (left_nxt == 0);
  assign frame = sel_a ? {hold_a, hold_b} : {hold_b, {SW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pending <= 1'b0;
      hold_a  <= '0;
      hold_b  <= '0;
    end else if (!en) pending <= 1'b0;
    else if (smp_stb && (sel_a | sel_b)) begin
      pending <= 1'b1;
      hold_a  <= smp_a;
      hold_b  <= smp_b;
    end else if (fall && fs_go) pending <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b0;
      active <= 1'b0;
      left   <= '0;
      len_q  <= '0;
      sh     <= '0;
      dout   <= 1'b0;
      fsync  <= 1'b0;
    end else if (fall) begin
      fsync <= fs_go;
      armed <= fs_go;
      left  <= left_nxt;
      if (armed) begin
        active <= 1'b1;
        dout   <= sh[FW-1];
        sh     <= sh << 1;
      end else if (left != 0) begin
        dout <= sh[FW-1];
        sh   <= sh << 1;
      end else begin
        active <= 1'b0;
        dout   <= 1'b0;
      end
      if (fs_go) begin
        sh    <= frame;
        len_q <= (sel_a & sel_b) ? LW'(FW) : LW'(SW);
      end
    end

  assign sdata    = active & dout;
  assign sdata_oe = active | ~idle_hiz;

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && cnt == last |=> cnt == 8'd0);
  // R3
  fs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync && fall |=> !fsync);
  // R5
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pending);
  // R8
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) |-> $stable(inv_q));
  // R9
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> left == '0);
endmodule

// File: tb/rx_sample_port_tb.sv
`timescale 1ns/1ps
module rx_sample_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 1'b0, wr_addr = 1'b0, smp_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] smp_a = '0, smp_b = '0;
  logic        bclk, fsync, sdata, sdata_oe;

  rx_sample_port #(.SW(16)) u_dut (.*);

  int checks = 0, fails = 0;
  bit m_inv = 0, m_sa = 0, m_sb = 0;
  int m_len = 32;
  logic [31:0] expq[$];
  string reqq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic pb = 1'b0, pfs = 1'b0;
  bit coll = 0;
  int nb = 0, frames = 0, fs_overlap = 0, oe_bad = 0, fs_rises = 0, bclk_hi = 0;
  logic [31:0] acc = '0;
  always @(negedge clk) begin
    logic b;
    b = bclk ^ m_inv;
    if (fsync && !pfs) fs_rises++;
    if (bclk) bclk_hi++;
    if (b && !pb) begin
      if (coll) begin
        if (!sdata_oe) oe_bad++;
        acc = {acc[30:0], sdata};
        nb++;
        if (nb == m_len) begin
          coll = 0;
          frames++;
          if (fsync) fs_overlap++;
          if (expq.size() == 0) chk(0, "R3", "unexpected frame", acc, 0);
          else chk(acc == expq[0], reqq[0], "frame data", acc, expq[0]);
          if (expq.size() != 0) begin
            void'(expq.pop_front());
            void'(reqq.pop_front());
          end
        end
      end
      if (fsync) begin coll = 1; nb = 0; acc = '0; end
    end
    pb  = b;
    pfs = fsync;
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b,
                      input bit expect_out, input string req);
    @(negedge clk); smp_a = a; smp_b = b; smp_stb = 1;
    @(negedge clk); smp_stb = 0;
    if (expect_out) begin
      expq.push_back((m_sa && m_sb) ? {a, b} : m_sa ? {16'h0, a} : {16'h0, b});
      reqq.push_back(req);
    end
  endtask

  task automatic wait_idle();
    while (expq.size() != 0 || coll) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic meas(output int hi, output int lo);
    @(negedge clk);
    while (!bclk) @(negedge clk);
    while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    hi = 0; while (bclk)  begin hi++; @(negedge clk); end
    lo = 0; while (!bclk) begin lo++; @(negedge clk); end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int hi, lo, f0, h0, r0;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk(bclk == 0 && fsync == 0 && sdata == 0, "R2", "outputs after reset",
        {bclk, fsync, sdata}, 0);
    chk(sdata_oe == 1, "R2", "data pin driven", sdata_oe, 1);
    rst_n = 1;
    h0 = bclk_hi;
    send(16'h1111, 16'h2222, 0, "R5");
    repeat (300) @(negedge clk);
    chk(bclk_hi == h0 && fs_rises == 0, "R5", "disabled port quiet", bclk_hi - h0, 0);

    // R1 even divide
    wr(0, 8'd4);
    m_sa = 1; m_sb = 1; m_len = 32;
    wr(1, 8'b00111);
    meas(hi, lo);
    chk(hi == 2 && lo == 2, "R1", "div4 high/low", {hi[15:0], lo[15:0]}, 32'h0002_0002);

    // R3 frame format, several patterns
    send(16'h1234, 16'hABCD, 1, "R3"); wait_idle();
    send(16'hFFFF, 16'h0000, 1, "R3"); wait_idle();
    send(16'h8001, 16'h7FFE, 1, "R3"); wait_idle();
    chk(frames == 3, "R3", "frame count", frames, 3);

    // R6 idle driven low
    chk(sdata_oe == 1 && sdata == 0, "R6", "idle driven low", {sdata_oe, sdata}, 2);

    // R9 back-to-back
    send(16'hC0DE, 16'h5A5A, 1, "R9");
    repeat (30) @(negedge clk);
    send(16'h0F0F, 16'hF00F, 1, "R9");
    wait_idle();
    chk(fs_overlap == 1, "R9", "sync in last bit slot", fs_overlap, 1);

    // R4 channel A only, then B only
    wr(1, 8'b00011); m_sb = 0; m_len = 16;
    send(16'hA5C3, 16'h9999, 1, "R4"); wait_idle();
    wr(1, 8'b00101); m_sa = 0; m_sb = 1;
    send(16'h7777, 16'h3C81, 1, "R4"); wait_idle();

    // R5 no channel selected
    wr(1, 8'b00001); m_sb = 0;
    r0 = fs_rises; f0 = frames;
    send(16'h1357, 16'h2468, 0, "R5");
    repeat (300) @(negedge clk);
    chk(fs_rises == r0 && frames == f0, "R5", "no sync without channel", fs_rises - r0, 0);

    // R6 tri-state idle
    wr(1, 8'b01111); m_sa = 1; m_sb = 1; m_len = 32;
    repeat (5) @(negedge clk);
    chk(sdata_oe == 0, "R6", "idle released", sdata_oe, 0);
    send(16'hBEEF, 16'hCAFE, 1, "R6"); wait_idle();
    chk(sdata_oe == 0, "R6", "released after frame", sdata_oe, 0);
    chk(oe_bad == 0, "R6", "oe during data bits", oe_bad, 0);

    // R7 disable during a frame
    wr(1, 8'b00111);
    f0 = frames;
    send(16'h4321, 16'h8765, 1, "R7");
    while (!fsync) @(negedge clk);
    repeat (40) @(negedge clk);
    wr(1, 8'b00110);
    wait_idle();
    chk(frames == f0 + 1, "R7", "frame completed after disable", frames - f0, 1);
    h0 = bclk_hi;
    send(16'h1111, 16'h1111, 0, "R5");
    repeat (300) @(negedge clk);
    chk(bclk_hi == h0, "R7", "clock stopped low", bclk_hi - h0, 0);
    chk(frames == f0 + 1, "R5", "strobe discarded while disabled", frames - f0, 1);

    // R1 odd divide and code 0
    wr(0, 8'd5); wr(1, 8'b00111);
    meas(hi, lo);
    chk(hi == 2 && lo == 3, "R1", "div5 high/low", {hi[15:0], lo[15:0]}, 32'h0002_0003);
    wr(1, 8'b00110); wr(0, 8'd0); wr(1, 8'b00111);
    meas(hi, lo);
    chk(hi == 128 && lo == 128, "R1", "code0 high/low", {hi[15:0], lo[15:0]}, 32'h0080_0080);
    wr(1, 8'b00110); repeat (300) @(negedge clk);

    // R8 inversion taken while stopped, ignored while running
    wr(0, 8'd5);
    m_inv = 1;
    wr(1, 8'b10111);
    meas(hi, lo);
    chk(hi == 3 && lo == 2, "R8", "inverted phases", {hi[15:0], lo[15:0]}, 32'h0003_0002);
    wr(1, 8'b00111);
    meas(hi, lo);
    chk(hi == 3 && lo == 2, "R8", "inversion kept while running", {hi[15:0], lo[15:0]}, 32'h0003_0002);
    send(16'h6E6E, 16'h1F2E, 1, "R8"); wait_idle();

    chk(expq.size() == 0, "R3", "scoreboard drained", expq.size(), 0);
    summary();
  end
endmodule